// File: doc/BRIEF.md
# DMA Stream Address Sequencer

The block runs one unidirectional transfer channel. Software programs a peripheral address, two memory buffer bases, an item count and a control word through a small register-write port. When started, the channel moves one data word per item. It issues a read at the source address, waits for the acknowledge and keeps the data. It then issues a write of that word at the destination address and waits for that acknowledge. A two-bit direction code decides which programmed address plays source and which plays destination.

In regular mode the channel stops after the programmed number of items and raises a sticky done flag. In double-buffer mode the channel switches to the other memory buffer each time a buffer's worth of items completes, reloads the count and keeps going, so software can refill or drain the idle buffer. The channel runs until software writes the control word with the run bit cleared. An optional step bit makes both addresses advance by one 32-bit word per item, and a reserved direction code is refused with an error flag.

Top module: `dma_chan_seq`

## Requirements
- R1: Direction code (control bits [2:1]) selects the addresses: 00 reads the peripheral address and writes the current memory buffer; 01 reads the current memory buffer and writes the peripheral address; 10 reads the peripheral address register and writes the current memory buffer.
- R2: Starting with direction code 11 sets `err`, leaves `busy` and `done` low and issues no bus request; the next valid start clears `err`.
- R3: Each item is one read followed by one write. `wr_data` equals the data accepted with that item's read, each request holds its address (and write data) until acknowledged, and the two requests are never high together.
- R4: In regular mode (control bit 3 = 0) a start with count N>0 performs exactly N items, then drops `busy` and raises `done`. Any start clears `done`.
- R5: A start with a programmed count of zero raises `done` within three cycles of the control write, with no bus request.
- R6: With the step bit (control bit 4) set, source and destination advance by 4 bytes after every item. With it clear, both stay fixed for the whole run.
- R7: In double-buffer mode, after every N items `mem_sel` toggles, the memory address restarts at the other buffer's base (register 3 when `mem_sel`=1, register 2 when 0), the peripheral address restarts at its base and the count reloads.
- R8: Writing the control word with the run bit (bit 0) clear while busy stops the channel after the current item's write. No further read is issued and `done` stays low.
- R9: A control write with the run bit set while the channel is busy is ignored: the running transfer keeps its direction, mode, step and addresses.
- R10: After reset `busy`, `done`, `err`, `mem_sel`, `rd_req` and `wr_req` are all low.

Register select: 0 control, 1 peripheral address, 2 memory base 0, 3 memory base 1, 4 item count (low 16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky refused-start flag |
| mem_sel | output | 1 | Memory buffer currently in use |

## Verification
Two events share a cycle here. The last item's write acknowledge can coincide with a pending stop, and the decrement that empties the counter coincides with the double-buffer reload and the buffer toggle. The bench provokes the first by writing the stop while a double-buffer run keeps wrapping, and the second with short buffer counts under random acknowledge delays. Every read and write address is compared against the item index, mapped through a bench function to buffer and offset, and the run-end flags and item totals are judged at the ports.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    DIR_P2M = 2'b00,
    DIR_M2P = 2'b01,
    DIR_M2M = 2'b10,
    DIR_RSV = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } st_e;

  localparam int SEL_CTRL   = 0;
  localparam int SEL_PER    = 1;
  localparam int SEL_MEM0   = 2;
  localparam int SEL_MEM1   = 3;
  localparam int SEL_COUNT  = 4;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_DBUF  = 3;
  localparam int CTRL_STEP  = 4;

  // memory is the source only when moving memory out to the peripheral
  function automatic logic src_from_mem(input dir_e d);
    return d == DIR_M2P;
  endfunction

  // memory is the destination for peripheral-in and memory copies
  function automatic logic dst_to_mem(input dir_e d);
    return (d == DIR_P2M) || (d == DIR_M2M);
  endfunction

endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int SW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] per_base,
  output logic [AW-1:0] mem_base0,
  output logic [AW-1:0] mem_base1,
  output logic [CW-1:0] cnt_prog,
  output dir_e          dir_q,
  output logic          dbuf_q,
  output logic          step_q,
  output logic          go_q,
  output logic          halt_q
);

  logic ctrl_hit;
  assign ctrl_hit = cfg_we && (cfg_sel == SW'(SEL_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_base  <= '0;
      mem_base0 <= '0;
      mem_base1 <= '0;
      cnt_prog  <= '0;
      dir_q     <= DIR_P2M;
      dbuf_q    <= 1'b0;
      step_q    <= 1'b0;
      go_q      <= 1'b0;
      halt_q    <= 1'b0;
    end else begin
      go_q   <= ctrl_hit &&  cfg_wdata[CTRL_RUN];
      halt_q <= ctrl_hit && !cfg_wdata[CTRL_RUN];
      if (ctrl_hit) begin
        dir_q  <= dir_e'(cfg_wdata[CTRL_DIR +: 2]);
        dbuf_q <= cfg_wdata[CTRL_DBUF];
        step_q <= cfg_wdata[CTRL_STEP];
      end
      if (cfg_we) begin
        case (int'(cfg_sel))
          SEL_PER:   per_base  <= cfg_wdata;
          SEL_MEM0:  mem_base0 <= cfg_wdata;
          SEL_MEM1:  mem_base1 <= cfg_wdata;
          SEL_COUNT: cnt_prog  <= cfg_wdata[CW-1:0];
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr
  import dma_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          buf_sel,
  input  dir_e          dir,
  input  logic          step_en,
  input  logic [AW-1:0] per_base,
  input  logic [AW-1:0] mem_base0,
  input  logic [AW-1:0] mem_base1,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a, input logic en);
    return en ? a + STEP_V : a;
  endfunction

  logic [AW-1:0] mem_base;
  assign mem_base = buf_sel ? mem_base1 : mem_base0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
    end else if (load) begin
      src_ptr <= src_from_mem(dir) ? mem_base : per_base;
      dst_ptr <= dst_to_mem(dir)   ? mem_base : per_base;
    end else if (advance) begin
      src_ptr <= bump(src_ptr, step_en);
      dst_ptr <= bump(dst_ptr, step_en);
    end
  end

endmodule

// File: rtl/dma_seq_ctr.sv
module dma_seq_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (load)        left_q <= load_val;
    else if (dec && left_q != '0) left_q <= left_q - CW'(1);
  end

  assign last = (left_q == CW'(1));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          halt,
  input  dir_e          cfg_dir,
  input  logic          cfg_dbuf,
  input  logic          cfg_step,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_ack,
  output logic          rd_req,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_sel,
  output dir_e          act_dir,
  output logic          act_step,
  output logic          ptr_load,
  output logic          cnt_load,
  output logic          item_done,
  output logic          buf_wrap,
  output logic          zero_hit
);

  st_e  st;
  logic act_dbuf;
  logic stop_pend;
  logic run_end;
  logic done_set;

  assign busy      = (st != ST_IDLE);
  assign rd_req    = (st == ST_RD);
  assign wr_req    = (st == ST_WR);
  assign item_done = wr_req && wr_ack;
  assign zero_hit  = (st == ST_LOAD) && cnt_zero;
  assign ptr_load  = (st == ST_LOAD) && !cnt_zero;
  assign cnt_load  = ptr_load;
  assign buf_wrap  = item_done && cnt_last && act_dbuf && !stop_pend;
  assign run_end   = item_done && (cnt_last ? !buf_wrap : stop_pend);
  assign done_set  = zero_hit || (item_done && cnt_last && !act_dbuf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      act_dir   <= DIR_P2M;
      act_dbuf  <= 1'b0;
      act_step  <= 1'b0;
      stop_pend <= 1'b0;
      mem_sel   <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      wr_data   <= '0;
    end else begin
      if (halt && busy) stop_pend <= 1'b1;
      if (done_set)     done      <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (go) begin
            done <= 1'b0;
            if (cfg_dir == DIR_RSV) begin
              err <= 1'b1;
            end else begin
              err       <= 1'b0;
              act_dir   <= cfg_dir;
              act_dbuf  <= cfg_dbuf;
              act_step  <= cfg_step;
              stop_pend <= 1'b0;
              mem_sel   <= 1'b0;
              st        <= ST_LOAD;
            end
          end
        end
        ST_LOAD: st <= cnt_zero ? ST_IDLE : ST_RD;
        ST_RD: begin
          if (rd_ack) begin
            wr_data <= rd_data;
            st      <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_ack) begin
            if (buf_wrap) begin
              mem_sel <= !mem_sel;
              st      <= ST_LOAD;
            end else if (run_end) begin
              st <= ST_IDLE;
            end else begin
              st <= ST_RD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int SW   = 3,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_sel
);

  logic [AW-1:0] per_base, mem_base0, mem_base1;
  logic [CW-1:0] cnt_prog;
  dir_e          cfg_dir, act_dir;
  logic          cfg_dbuf, cfg_step, act_step;
  logic          go_q, halt_q;
  logic          ptr_load, cnt_load, cnt_last, cnt_zero;
  logic          item_done, buf_wrap, zero_hit;

  assign cnt_zero = (cnt_prog == '0);

  dma_seq_cfg #(.AW(AW), .CW(CW), .SW(SW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .per_base(per_base), .mem_base0(mem_base0),
    .mem_base1(mem_base1), .cnt_prog(cnt_prog), .dir_q(cfg_dir),
    .dbuf_q(cfg_dbuf), .step_q(cfg_step), .go_q(go_q), .halt_q(halt_q)
  );

  dma_seq_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go_q), .halt(halt_q),
    .cfg_dir(cfg_dir), .cfg_dbuf(cfg_dbuf), .cfg_step(cfg_step),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err), .mem_sel(mem_sel),
    .act_dir(act_dir), .act_step(act_step),
    .ptr_load(ptr_load), .cnt_load(cnt_load),
    .item_done(item_done), .buf_wrap(buf_wrap), .zero_hit(zero_hit)
  );

  dma_seq_ptr #(.AW(AW), .STEP(STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .advance(item_done),
    .buf_sel(mem_sel), .dir(act_dir), .step_en(act_step),
    .per_base(per_base), .mem_base0(mem_base0), .mem_base1(mem_base1),
    .src_ptr(rd_addr), .dst_ptr(wr_addr)
  );

  dma_seq_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_prog),
    .dec(item_done), .last(cnt_last)
  );

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mem_sel,
  input logic          item_done,
  input logic          buf_wrap,
  input logic          zero_hit
);

  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done && !rd_req && !wr_req));

  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(item_done) || $past(zero_hit)));

  // R5
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> (done && !busy));

  // R7
  sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel != $past(mem_sel)) |-> ($past(buf_wrap) || !$past(busy)));

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) |-> busy);

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_addr(rd_addr), .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .done(done), .err(err),
  .mem_sel(mem_sel), .item_done(item_done), .buf_wrap(buf_wrap),
  .zero_hit(zero_hit)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_req, wr_req, busy, done, err, mem_sel;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic        rd_ack = 1'b0, wr_ack = 1'b0;
  logic [31:0] rd_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the programmed transfer
  int          m_dir, m_cnt, rd_k, wr_k;
  bit          m_dbuf, m_step;
  logic [31:0] m_per, m_m0, m_m1, last_rd;

  always #10 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .err(err), .mem_sel(mem_sel)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // item k: which buffer, which slot in it
  function automatic logic [31:0] mem_at(int k);
    int b = m_dbuf ? (k / m_cnt) % 2 : 0;
    int i = m_dbuf ? k % m_cnt : k;
    return (b != 0 ? m_m1 : m_m0) + (m_step ? 32'(4 * i) : 32'd0);
  endfunction

  function automatic logic [31:0] per_at(int k);
    int i = m_dbuf ? k % m_cnt : k;
    return m_per + (m_step ? 32'(4 * i) : 32'd0);
  endfunction

  function automatic logic [31:0] exp_src(int k);
    return (m_dir == 1) ? mem_at(k) : per_at(k);
  endfunction

  function automatic logic [31:0] exp_dst(int k);
    return (m_dir == 1) ? per_at(k) : mem_at(k);
  endfunction

  function automatic string addr_tag();
    return m_dbuf ? "R7" : (m_step ? "R6" : "R1");
  endfunction

  // bus responder with random acknowledge delay
  initial begin : responder
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      wr_ack = 1'b0;
      if (rd_req && ($urandom % 3) != 0) begin
        chk(rd_addr == exp_src(rd_k), addr_tag(), rd_addr, exp_src(rd_k));
        chk(rd_k == wr_k, "R3 read order", 32'(rd_k), 32'(wr_k));
        rd_data = $urandom;
        last_rd = rd_data;
        rd_k++;
        rd_ack = 1'b1;
      end else if (wr_req && ($urandom % 3) != 0) begin
        chk(wr_addr == exp_dst(wr_k), addr_tag(), wr_addr, exp_dst(wr_k));
        chk(wr_data == last_rd, "R3 data", wr_data, last_rd);
        wr_k++;
        wr_ack = 1'b1;
      end
    end
  end

  task automatic cfg_write(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 3'(sel);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int dir, input bit dbuf, input bit step,
                       input logic [31:0] per, input logic [31:0] m0,
                       input logic [31:0] m1, input int cnt);
    m_dir = dir; m_dbuf = dbuf; m_step = step;
    m_per = per; m_m0 = m0; m_m1 = m1; m_cnt = cnt;
    cfg_write(1, per);
    cfg_write(2, m0);
    cfg_write(3, m1);
    cfg_write(4, 32'(cnt));
    rd_k = 0;
    wr_k = 0;
  endtask

  function automatic logic [31:0] ctrl_word(input int dir, input bit dbuf,
                                            input bit step, input bit run);
    return {27'd0, step, dbuf, 2'(dir), run};
  endfunction

  task automatic wait_idle();
    for (int c = 0; c < 4000 && busy; c++) @(negedge clk);
  endtask

  task automatic run_regular(input int dir, input bit step,
                             input logic [31:0] per, input logic [31:0] m0, input int cnt);
    setup(dir, 1'b0, step, per, m0, 32'hDEAD_0000, cnt);
    cfg_write(0, ctrl_word(dir, 1'b0, step, 1'b1));
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R4 done cleared on start", 32'(done), 32'd0);
    chk(busy == 1'b1, "R4 busy while running", 32'(busy), 32'd1);
    wait_idle();
    chk(done == 1'b1, "R4 done at end", 32'(done), 32'd1);
    chk(wr_k == cnt, "R4 item total", 32'(wr_k), 32'(cnt));
    chk(err == 1'b0, "R2 err clear after valid start", 32'(err), 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk({busy, done, err, mem_sel, rd_req, wr_req} == 6'd0, "R10 reset outputs",
        32'({busy, done, err, mem_sel, rd_req, wr_req}), 32'd0);

    // R1 each direction, fixed addresses
    run_regular(0, 1'b0, 32'h4000_1000, 32'h2000_0000, 3);
    run_regular(1, 1'b0, 32'h4000_2000, 32'h2000_0100, 2);
    run_regular(2, 1'b0, 32'h0800_0000, 32'h2000_0200, 4);

    // R6 stepping, including address wrap past the top of the space
    run_regular(1, 1'b1, 32'h4000_3000, 32'h2000_0400, 5);
    run_regular(2, 1'b1, 32'hFFFF_FFF8, 32'h2000_0800, 4);

    // R2 reserved direction
    setup(3, 1'b0, 1'b0, 32'h1, 32'h2, 32'h3, 4);
    cfg_write(0, ctrl_word(3, 1'b0, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R2 err set", 32'(err), 32'd1);
    chk(busy == 1'b0, "R2 no start", 32'(busy), 32'd0);
    chk(done == 1'b0, "R2 done low", 32'(done), 32'd0);
    chk(rd_k == 0, "R2 no bus request", 32'(rd_k), 32'd0);
    run_regular(0, 1'b1, 32'h4000_5000, 32'h2000_1000, 2);

    // R5 zero count
    setup(0, 1'b0, 1'b0, 32'h4000_6000, 32'h2000_2000, 32'h0, 0);
    cfg_write(0, ctrl_word(0, 1'b0, 1'b0, 1'b1));
    repeat (2) @(negedge clk);
    chk(done == 1'b1, "R5 immediate done", 32'(done), 32'd1);
    chk(busy == 1'b0, "R5 idle", 32'(busy), 32'd0);
    repeat (5) @(negedge clk);
    chk(rd_k == 0, "R5 no bus request", 32'(rd_k), 32'd0);

    // R9 start write while busy is ignored
    setup(1, 1'b0, 1'b1, 32'h4000_7000, 32'h2000_3000, 32'h0, 6);
    cfg_write(0, ctrl_word(1, 1'b0, 1'b1, 1'b1));
    while (wr_k < 2) @(posedge clk);
    cfg_write(0, ctrl_word(0, 1'b1, 1'b0, 1'b1));
    wait_idle();
    chk(wr_k == 6, "R9 run unchanged", 32'(wr_k), 32'd6);
    chk(done == 1'b1, "R9 run completed", 32'(done), 32'd1);

    // R7 double buffer, then R8 stop
    setup(0, 1'b1, 1'b1, 32'h4000_8000, 32'h2000_4000, 32'h2000_5000, 3);
    cfg_write(0, ctrl_word(0, 1'b1, 1'b1, 1'b1));
    while (wr_k < 4) @(posedge clk);
    #2;
    chk(mem_sel == 1'b1, "R7 second buffer", 32'(mem_sel), 32'd1);
    while (wr_k < 7) @(posedge clk);
    #2;
    chk(mem_sel == 1'b0, "R7 back to first buffer", 32'(mem_sel), 32'd0);
    chk(busy == 1'b1, "R7 keeps running", 32'(busy), 32'd1);
    cfg_write(0, ctrl_word(0, 1'b1, 1'b1, 1'b0));
    wait_idle();
    chk(busy == 1'b0, "R8 stopped", 32'(busy), 32'd0);
    chk(done == 1'b0, "R8 no done on stop", 32'(done), 32'd0);
    chk(rd_k == wr_k, "R8 item finished", 32'(rd_k), 32'(wr_k));
    repeat (20) @(negedge clk);
    chk(rd_k == wr_k && !rd_req, "R8 no more reads", 32'(rd_k), 32'(wr_k));

    // R1 R6 random regular runs
    for (int t = 0; t < 12; t++) begin
      int d = int'($urandom % 3);
      bit s = 1'($urandom % 2);
      int n = 1 + int'($urandom % 6);
      run_regular(d, s, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, n);
    end

    // R7 random double-buffer runs, stopped after a few wraps
    for (int t = 0; t < 4; t++) begin
      int d = int'($urandom % 3);
      int n = 1 + int'($urandom % 3);
      setup(d, 1'b1, 1'($urandom % 2), $urandom & 32'hFFFF_FFFC,
            $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, n);
      cfg_write(0, ctrl_word(d, 1'b1, m_step, 1'b1));
      while (wr_k < 3 * n + 1) @(posedge clk);
      cfg_write(0, ctrl_word(d, 1'b1, m_step, 1'b0));
      wait_idle();
      chk(!busy && !done, "R8 stop after wraps", 32'({busy, done}), 32'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule